// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a byte-wide I/O bus access to 256 internal 8-bit configuration registers through just two port offsets. A byte written at offset 0 becomes the current index. Offset 1 then reaches the register that the index selects. Writes through offset 1 change that register only if its index is not write-protected. Reads through offset 1 always return the selected register.

The protected indices form an irregular map. The whole lower range is protected, and the upper range is a patchwork of writable and locked entries. A handful of registers in the upper range leave reset with non-zero values.

The window answers the bus only while an enable bit is set. That bit lives in a separate bridge configuration byte, which the block models as a small write port. The window leaves reset switched off. Read data comes from a register, so it is valid one clock after the read strobe.

Top module: `idx_cfg_window`

## Requirements
- R1: While the window is enabled, a write to offset 0 (`busAddr`=0) loads the index register. The index resets to 0x00 and keeps its value across data reads and writes, with no auto-increment.
- R2: While the window is enabled, a read at offset 0 returns the current index.
- R3: While the window is enabled, a write at offset 1 (`busAddr`=1) stores the byte in the selected register when the index is one of the writable indices: 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R4: A write at offset 1 leaves the selected register unchanged when the index is any of the others: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R5: Read data is registered. `busRdata` resets to 0xFF and takes its new value on the clock edge that samples `busRd`. It holds that value until the next read.
- R6: While the window is enabled, a read at offset 1 returns the selected register, whether or not that register is protected.
- R7: After reset every register holds 0x00, except these: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE.
- R8: The window is disabled after reset. A bridge write (`brgWr`) at bridge offset 0x85 sets the enable from bit 1 of `brgWdata`. Bridge writes at any other offset, and the other data bits, have no effect.
- R9: While the window is disabled, writes to either offset change nothing, and any read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 1 | Port offset: 0 selects the index, 1 selects the data |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| brgWr | input | 1 | Bridge configuration write strobe |
| brgAddr | input | 8 | Bridge configuration offset |
| brgWdata | input | 8 | Bridge configuration write data |

## Verification
The assertions take the bus inputs to be known and free of X from reset onward. They also assume that a read and a write never arrive in the same cycle, because the data-write check compares the register with the byte on the bus in the cycle before. The stimulus changes every input on the falling edge, gives each access exactly one cycle of strobe, and never raises `busRd` and `busWr` together. Enable changes arrive only through the bridge port, in cycles that carry no bus access.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef struct packed {
    logic idxWe;    // load index register
    logic dataWe;   // store into the selected register
    logic rdIdx;    // capture the index into read data
    logic rdData;   // capture the selected register into read data
    logic rdBlank;  // capture the not-claimed value into read data
  } winStrobes_t;

  // Write-protect map over the 8-bit index space
  function automatic logic isLocked(input logic [7:0] idx);
    logic locked;
    if (idx <= 8'hDF) begin
      locked = 1'b1;
    end else begin
      case (idx)
        8'hE4, 8'hE5,
        8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
        8'hF3, 8'hF5, 8'hF7,
        8'hF9, 8'hFA, 8'hFB,
        8'hFD, 8'hFE, 8'hFF: locked = 1'b1;
        default:             locked = 1'b0;
      endcase
    end
    return locked;
  endfunction

  // Value each register takes on reset
  function automatic logic [7:0] bootValue(input logic [7:0] idx);
    logic [7:0] v;
    case (idx)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      8'hE7:   v = 8'hFE;
      8'hE8:   v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int                    IDX_W     = 8,
  parameter int                    BRG_AW    = 8,
  parameter logic [BRG_AW-1:0]     EN_OFFSET = 8'h85,
  parameter int                    EN_BIT    = 1,
  parameter int                    DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              brgWr,
  input  logic [BRG_AW-1:0] brgAddr,
  input  logic [DATA_W-1:0] brgWdata,
  input  logic [IDX_W-1:0]  curIdx,
  output winStrobes_t       strb,
  output logic              winOn
);

  logic enHit;
  logic idxLocked;

  assign enHit     = brgWr && (brgAddr == EN_OFFSET);
  assign idxLocked = isLocked(8'(curIdx));

  // Enable bit held from the bridge configuration write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winOn <= 1'b0;
    else if (enHit) winOn <= brgWdata[EN_BIT];
  end

  always_comb begin
    strb         = '0;
    strb.idxWe   = winOn && busWr && !busAddr;
    strb.dataWe  = winOn && busWr && busAddr && !idxLocked;
    strb.rdIdx   = winOn && busRd && !busAddr;
    strb.rdData  = winOn && busRd && busAddr;
    strb.rdBlank = !winOn && busRd;
  end

  // R8: the enable moves only on a bridge write at the enable offset
  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enHit |=> $stable(winOn));

  // R8: a bridge write at the enable offset takes bit EN_BIT
  assert_en_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    enHit |=> (winOn == $past(brgWdata[EN_BIT])));

endmodule

// File: rtl/cfgwin_datapath.sv
module cfgwin_datapath
  import cfgwin_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobes_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [IDX_W-1:0]  curIdx,
  output logic [DATA_W-1:0] busRdata
);

  localparam int NUM_REGS = 1 << IDX_W;
  localparam logic [DATA_W-1:0] NOT_CLAIMED = '1;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curIdx <= '0;
    else if (strb.idxWe) curIdx <= busWdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regFile[i] <= DATA_W'(bootValue(8'(i)));
      end
    end else if (strb.dataWe) begin
      regFile[curIdx] <= busWdata;
    end
  end

  assign selReg = regFile[curIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= NOT_CLAIMED;
    else if (strb.rdData) busRdata <= selReg;
    else if (strb.rdIdx) busRdata <= DATA_W'(curIdx);
    else if (strb.rdBlank) busRdata <= NOT_CLAIMED;
  end

  // R1: the index holds unless a window index write is strobed
  assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idxWe |=> $stable(curIdx));

  // R3: a strobed data write lands in the register the index selected
  assert_data_store_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWe |=> (regFile[$past(curIdx)] == $past(busWdata)));

  // R5: read data holds between reads
  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdIdx || strb.rdData || strb.rdBlank) |=> $stable(busRdata));

  // The control never asks for two read sources at once
  assert_one_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdIdx, strb.rdData, strb.rdBlank}));

endmodule

// File: rtl/idx_cfg_window.sv
module idx_cfg_window
  import cfgwin_pkg::*;
#(
  parameter int                IDX_W     = 8,
  parameter int                DATA_W    = 8,
  parameter int                BRG_AW    = 8,
  parameter logic [BRG_AW-1:0] EN_OFFSET = 8'h85,
  parameter int                EN_BIT    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              brgWr,
  input  logic [BRG_AW-1:0] brgAddr,
  input  logic [DATA_W-1:0] brgWdata
);

  winStrobes_t       strb;
  logic              winOn;
  logic [IDX_W-1:0]  curIdx;

  cfgwin_ctrl #(
    .IDX_W(IDX_W), .BRG_AW(BRG_AW), .EN_OFFSET(EN_OFFSET),
    .EN_BIT(EN_BIT), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .brgWr(brgWr), .brgAddr(brgAddr), .brgWdata(brgWdata),
    .curIdx(curIdx), .strb(strb), .winOn(winOn)
  );

  cfgwin_datapath #(
    .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busWdata(busWdata), .curIdx(curIdx), .busRdata(busRdata)
  );

  // R9: a read while disabled answers with the not-claimed value
  assert_off_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !winOn) |=> (busRdata == '1));

  // R9: an index write while disabled leaves the index alone
  assert_off_idx_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && !winOn) |=> $stable(curIdx));

  // R1: an enabled index write loads the bus byte
  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && winOn) |=> (curIdx == $past(busWdata[IDX_W-1:0])));

endmodule

// File: tb/idx_cfg_window_tb_top.sv
module idx_cfg_window_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       brgWr = 1'b0;
  logic [7:0] brgAddr = 8'h00;
  logic [7:0] brgWdata = 8'h00;

  int checks = 0;
  int fails  = 0;

  // Reference state built from the requirements
  logic [7:0] mdl [256];
  logic [7:0] mIdx = 8'h00;
  logic       mEn  = 1'b0;

  logic [7:0] expQ [$];
  string      tagQ [$];
  logic       sawRd = 1'b0;

  always #10 clk = ~clk;

  idx_cfg_window dut_i (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata),
    .brgWr(brgWr), .brgAddr(brgAddr), .brgWdata(brgWdata)
  );

  function automatic logic benchWritable(input logic [7:0] i);
    case (i)
      8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hE7, 8'hE8,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
      8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] benchBoot(input logic [7:0] i);
    case (i)
      8'hE0: return 8'h3C;
      8'hE2: return 8'h03;
      8'hE3: return 8'hFC;
      8'hE6: return 8'hDE;
      8'hE7: return 8'hFE;
      8'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Driver tasks: called at a falling edge, return at the next one
  task automatic busWrite(input logic a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    if (mEn) begin
      if (!a) mIdx = d;
      else if (benchWritable(mIdx)) mdl[mIdx] = d;
    end
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic a, input string tag);
    logic [7:0] e;
    if (!mEn) e = 8'hFF;
    else if (a) e = mdl[mIdx];
    else e = mIdx;
    expQ.push_back(e);
    tagQ.push_back(tag);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic brgWrite(input logic [7:0] a, input logic [7:0] d);
    brgAddr = a; brgWdata = d; brgWr = 1'b1;
    if (a == 8'h85) mEn = d[1];
    @(negedge clk);
    brgWr = 1'b0;
  endtask

  // Monitor: pops the expected value the cycle after a read strobe
  always @(posedge clk) sawRd <= busRd;

  always @(negedge clk) begin
    if (sawRd) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: got %02h expected none (no queued read)", busRdata);
      end else begin
        check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = benchBoot(8'(i));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R5: read data reset value
    check(busRdata, 8'hFF, "R5 reset rdata");

    // R8/R9: disabled out of reset, writes ignored, reads 0xFF
    busWrite(1'b0, 8'hE0);
    busWrite(1'b1, 8'h55);
    busRead(1'b1, "R9 disabled data read");
    busRead(1'b0, "R9 disabled index read");

    // R8: wrong offset and wrong bit leave it disabled
    brgWrite(8'h84, 8'h02);
    busRead(1'b1, "R8 other bridge offset");
    brgWrite(8'h85, 8'hFD);
    busRead(1'b1, "R8 enable bit clear");
    brgWrite(8'h85, 8'h02);

    // R1/R2: index still at reset value after ignored write
    busRead(1'b0, "R1 index reset and R9 ignored index write");
    busWrite(1'b0, 8'hE0);
    busRead(1'b1, "R9 ignored data write / R7 E0");

    // R7: all reset values
    for (int i = 0; i < 256; i++) begin
      busWrite(1'b0, 8'(i));
      busRead(1'b1, "R7 reset value");
    end

    // R3/R4: write every index, read back
    for (int i = 0; i < 256; i++) begin
      busWrite(1'b0, 8'(i));
      busWrite(1'b1, 8'(i) ^ 8'hA5);
    end
    for (int i = 0; i < 256; i++) begin
      busWrite(1'b0, 8'(i));
      busRead(1'b1, benchWritable(8'(i)) ? "R3 writable readback" : "R4/R6 protected readback");
    end

    // R1/R2: index holds across data accesses, no auto-increment
    busWrite(1'b0, 8'hF4);
    busWrite(1'b1, 8'h11);
    busWrite(1'b1, 8'h22);
    busRead(1'b1, "R1 no auto-increment");
    busRead(1'b1, "R6 repeated read");
    busRead(1'b0, "R2 index readback");
    busWrite(1'b0, 8'hE5);
    busWrite(1'b1, 8'h77);
    busRead(1'b1, "R4 locked E5");
    busRead(1'b0, "R2 index E5");

    // R5: value held with no reads
    busWrite(1'b0, 8'hE6);
    busRead(1'b1, "R5 read E6");
    repeat (3) begin
      @(negedge clk);
      check(busRdata, mdl[8'hE6], "R5 hold between reads");
    end

    // R9: disable, try writes, re-enable, confirm unchanged
    brgWrite(8'h85, 8'h00);
    busWrite(1'b0, 8'hF0);
    busWrite(1'b1, 8'h99);
    busRead(1'b1, "R9 disabled read after enable");
    brgWrite(8'h85, 8'hFF);
    busRead(1'b0, "R9 index unchanged while off");
    busRead(1'b1, "R9 data unchanged while off");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5: got %0d pending expected 0", expQ.size());
    end
    finishRun();
  end

endmodule